// File: doc/BRIEF.md
# Pipelined Byte-Write SRAM Datapath

This block is the storage and data side of a synchronous pipelined SRAM built from words of several byte lanes (four lanes of eight bits by default). An address front end hands it a word address and a select flag that says the current clock is an access. Alongside these come three active-low write controls: a global write that stores every lane, a byte write enable, and one byte select per lane. It also receives an asynchronous active-low output enable and an active-high sleep input. The bidirectional data bus is modelled as a separate data input, a data output and a drive-enable output. An external pad ring or bus model combines these into a tri-state bus.

Write data is captured into an input data register at the clock edge of the write. It is committed to the array at the next edge. A read in that next cycle to the same word is merged with the pending bytes, so a back-to-back write then read returns the new data. The read path is registered: the word addressed at one edge is held at the output from that edge until the next accepted read.

The drive enable follows the output enable combinationally. It is forced off in three cases: after a cycle that was not a read, on the first read that follows a deselected or sleeping cycle, and while sleep is high. During sleep the array contents are kept and all accesses are dropped. A parameter chooses between the late-write data register and a direct write at the access edge.

Top module: `bytewr_sram_dp`

## Requirements
- R1: While rst_n is low and after its release, rdata_o is all zeros and drive_o is 0 until the first read is accepted.
- R2: A cycle is an access when sel_i is 1 and sleep_i is 0 at the rising edge. An access with gw_n = 0 writes all lanes of wdata_i to the word at addr_i, whatever bwe_n and bsel_n hold.
- R3: With gw_n = 1 and bwe_n = 0, an access writes exactly the lanes i whose bsel_n[i] is 0, where lane i is bits 8i+7..8i of the word; the other lanes keep their contents. An access with gw_n = 1 and either bwe_n = 1 or bsel_n = 4'b1111 is a read.
- R4: A read accepted at rising edge k presents the addressed word on rdata_o from edge k on. rdata_o holds that value until the next accepted read.
- R5: In the cycle after an accepted read that was itself preceded by an access, drive_o equals the inverse of oe_n, reacting to oe_n without waiting for a clock. After a write access or a non-access cycle, drive_o is 0.
- R6: For a read accepted at an edge whose previous edge was not an access (sel_i low or sleep_i high), drive_o stays 0 in the following cycle even with oe_n low.
- R7: While sleep_i is high, no write or read is accepted, rdata_o keeps its value and drive_o is 0. Array contents are preserved across sleep.
- R8: A read of the same address in the cycle right after a write returns the newly written lanes merged with the unwritten old lanes.
- R9: A cycle with sel_i = 0 changes nothing in the array, whatever the write controls and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control and output registers |
| sel_i | input | 1 | Access strobe from the address front end |
| addr_i | input | ADDR_W (10) | Word address |
| gw_n | input | 1 | Global write, active low, writes all lanes |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | LANES (4) | Per-lane byte selects, active low |
| wdata_i | input | LANES*LANE_W (32) | Write data from the bus |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request, active high |
| rdata_o | output | LANES*LANE_W (32) | Registered read data |
| drive_o | output | 1 | Bus drive enable for rdata_o |

## Verification
Read data is due one edge after the read is sampled. The bench drives inputs on the falling edge, lets the model act on the rising edge, and compares rdata_o at the next falling edge. The write takes effect in the array one edge later than its access, so back-to-back write-then-read pairs to a small address window are checked against a bench memory model that applies writes immediately. drive_o is compared in the same half-cycle window, and additionally checked a fraction of a cycle after oe_n changes with no clock edge in between, which confirms the combinational output-enable path.

// File: rtl/sramdp_pkg.sv
package sramdp_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } sramdp_op_t;

   function automatic bit is_pow_lane(input int unsigned w);
      return (w >= 1) && (w <= 64);
   endfunction

endpackage

// File: rtl/sramdp_cmd_dec.sv
module sramdp_cmd_dec
   import sramdp_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             sel_i,
   input  logic             sleep_i,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bsel_n,
   output sramdp_op_t       op_o,
   output logic [LANES-1:0] lane_mask_o
);

   logic             access;
   logic [LANES-1:0] mask;

   always_comb begin
      access = sel_i & ~sleep_i;
      if (!gw_n) begin
         mask = '1;
      end else if (!bwe_n) begin
         mask = ~bsel_n;
      end else begin
         mask = '0;
      end
   end

   always_comb begin
      if (!access) begin
         op_o = OP_NONE;
      end else if (|mask) begin
         op_o = OP_WRITE;
      end else begin
         op_o = OP_READ;
      end
   end

   assign lane_mask_o = mask;

endmodule

// File: rtl/sramdp_wr_stage.sv
module sramdp_wr_stage #(
   parameter int ADDR_W     = 10,
   parameter int LANES      = 4,
   parameter int LANE_W     = 8,
   parameter bit LATE_WRITE = 1'b1,
   localparam int DATA_W    = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [LANES-1:0]  mask_i,
   output logic [LANES-1:0]  lane_we_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o
);

   generate
      if (LATE_WRITE) begin : g_late
         logic              pend_v;
         logic [ADDR_W-1:0] pend_addr;
         logic [DATA_W-1:0] pend_data;
         logic [LANES-1:0]  pend_mask;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_v <= 1'b0;
            end else begin
               pend_v <= wr_req;
            end
         end

         always_ff @(posedge clk) begin
            if (wr_req) begin
               pend_addr <= addr_i;
               pend_data <= wdata_i;
               pend_mask <= mask_i;
            end
         end

         assign lane_we_o = pend_v ? pend_mask : '0;
         assign wr_addr_o = pend_addr;
         assign wr_data_o = pend_data;
      end else begin : g_direct
         assign lane_we_o = wr_req ? mask_i : '0;
         assign wr_addr_o = addr_i;
         assign wr_data_o = wdata_i;
      end
   endgenerate

endmodule

// File: rtl/sramdp_lane.sv
module sramdp_lane #(
   parameter int ADDR_W = 10,
   parameter int LANE_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LANE_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [LANE_W-1:0] rd_q
);

   logic [LANE_W-1:0] store [DEPTH];
   logic              fwd_hit;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         store[wr_addr] <= wr_data;
      end
   end

   assign fwd_hit = wr_en && (wr_addr == rd_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (rd_en) begin
         rd_q <= fwd_hit ? wr_data : store[rd_addr];
      end
   end

endmodule

// File: rtl/sramdp_out_ctl.sv
module sramdp_out_ctl
   import sramdp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  sramdp_op_t op_i,
   input  logic       oe_n,
   input  logic       sleep_i,
   output logic       drive_o
);

   logic prev_access;
   logic rd_valid;
   logic rd_first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_access <= 1'b0;
         rd_valid    <= 1'b0;
         rd_first    <= 1'b0;
      end else begin
         prev_access <= (op_i != OP_NONE);
         rd_valid    <= (op_i == OP_READ);
         rd_first    <= (op_i == OP_READ) && !prev_access;
      end
   end

   assign drive_o = rd_valid & ~rd_first & ~oe_n & ~sleep_i;

endmodule

// File: rtl/bytewr_sram_dp.sv
module bytewr_sram_dp
   import sramdp_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int LANES      = 4,
   parameter int LANE_W     = 8,
   parameter bit LATE_WRITE = 1'b1,
   localparam int DATA_W    = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              gw_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  bsel_n,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              oe_n,
   input  logic              sleep_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              drive_o
);

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 16)
         else $fatal(1, "bytewr_sram_dp: ADDR_W out of range");
      assert (LANES >= 1 && LANES <= 16)
         else $fatal(1, "bytewr_sram_dp: LANES out of range");
      assert (is_pow_lane(LANE_W))
         else $fatal(1, "bytewr_sram_dp: LANE_W out of range");
   end

   sramdp_op_t        op;
   logic [LANES-1:0]  lane_mask;
   logic [LANES-1:0]  lane_we;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              rd_en;

   sramdp_cmd_dec #(
      .LANES (LANES)
   ) u_dec (
      .sel_i       (sel_i),
      .sleep_i     (sleep_i),
      .gw_n        (gw_n),
      .bwe_n       (bwe_n),
      .bsel_n      (bsel_n),
      .op_o        (op),
      .lane_mask_o (lane_mask)
   );

   sramdp_wr_stage #(
      .ADDR_W     (ADDR_W),
      .LANES      (LANES),
      .LANE_W     (LANE_W),
      .LATE_WRITE (LATE_WRITE)
   ) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (op == OP_WRITE),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .mask_i    (lane_mask),
      .lane_we_o (lane_we),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data)
   );

   assign rd_en = (op == OP_READ);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         sramdp_lane #(
            .ADDR_W (ADDR_W),
            .LANE_W (LANE_W)
         ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (lane_we[g]),
            .wr_addr (wr_addr),
            .wr_data (wr_data[g*LANE_W +: LANE_W]),
            .rd_en   (rd_en),
            .rd_addr (addr_i),
            .rd_q    (rdata_o[g*LANE_W +: LANE_W])
         );
      end
   endgenerate

   sramdp_out_ctl u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_i    (op),
      .oe_n    (oe_n),
      .sleep_i (sleep_i),
      .drive_o (drive_o)
   );

endmodule

// File: rtl/sramdp_chk.sv
module sramdp_chk #(
   parameter int ADDR_W = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              gw_n,
   input logic              bwe_n,
   input logic [LANES-1:0]  bsel_n,
   input logic              oe_n,
   input logic              sleep_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              drive_o
);

   logic acc;
   logic rd_req;
   logic wr_req;

   assign acc    = sel_i & ~sleep_i;
   assign rd_req = acc & gw_n & (bwe_n | (&bsel_n));
   assign wr_req = acc & ~rd_req;

   // R6: first read after a non-access cycle is never driven
   assert_first_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !$past(acc)) |=> !drive_o);

   // R5: a following read drives as the output enable says
   assert_oe_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && $past(acc)) |=> (sleep_i || (drive_o == !oe_n)));

   // R5: no drive after a write access
   assert_no_drive_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> !drive_o);

   // R7: a sleeping edge accepts no read
   assert_sleep_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> !drive_o);

   // R4: read data only moves on an accepted read
   assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(rdata_o));

endmodule

bind bytewr_sram_dp sramdp_chk #(
   .ADDR_W (ADDR_W),
   .LANES  (LANES),
   .LANE_W (LANE_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel_i   (sel_i),
   .addr_i  (addr_i),
   .gw_n    (gw_n),
   .bwe_n   (bwe_n),
   .bsel_n  (bsel_n),
   .oe_n    (oe_n),
   .sleep_i (sleep_i),
   .rdata_o (rdata_o),
   .drive_o (drive_o)
);

// File: tb/bytewr_sram_dp_tb.sv
module bytewr_sram_dp_tb;

   localparam int AW = 10;
   localparam int NW = 1 << AW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_i = 1'b0;
   logic [9:0]  addr_i = '0;
   logic        gw_n = 1'b1;
   logic        bwe_n = 1'b1;
   logic [3:0]  bsel_n = 4'hF;
   logic [31:0] wdata_i = '0;
   logic        oe_n = 1'b0;
   logic        sleep_i = 1'b0;
   logic [31:0] rdata_o;
   logic        drive_o;

   always #2 clk = ~clk;

   bytewr_sram_dp u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_i   (sel_i),
      .addr_i  (addr_i),
      .gw_n    (gw_n),
      .bwe_n   (bwe_n),
      .bsel_n  (bsel_n),
      .wdata_i (wdata_i),
      .oe_n    (oe_n),
      .sleep_i (sleep_i),
      .rdata_o (rdata_o),
      .drive_o (drive_o)
   );

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [31:0] mdl [NW];
   logic [31:0] e_rd = '0;
   logic        e_val = 1'b0;
   logic        e_first = 1'b0;
   logic        e_prev = 1'b0;

   function automatic logic [3:0] lanes_of(logic g, logic b, logic [3:0] bs);
      if (!g) return 4'hF;
      if (!b) return ~bs;
      return 4'h0;
   endfunction

   function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) begin
         r[i*8 +: 8] = m[i] ? nw[i*8 +: 8] : old[i*8 +: 8];
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic s, input logic [9:0] a, input logic g, input logic b,
                      input logic [3:0] bs, input logic [31:0] d, input logic o, input logic z);
      logic [3:0] m;
      logic       acc;
      logic       ed;
      sel_i = s; addr_i = a; gw_n = g; bwe_n = b; bsel_n = bs;
      wdata_i = d; oe_n = o; sleep_i = z;
      @(posedge clk);
      acc = s & ~z;
      m = lanes_of(g, b, bs);
      if (acc && m != 4'h0) begin
         mdl[a] = merge(mdl[a], d, m);
         e_val = 1'b0;
         e_first = 1'b0;
      end else if (acc) begin
         e_rd = mdl[a];
         e_val = 1'b1;
         e_first = !e_prev;
      end else begin
         e_val = 1'b0;
         e_first = 1'b0;
      end
      e_prev = acc;
      @(negedge clk);
      ed = e_val & ~e_first & ~o & ~z;
      chk(rdata_o === e_rd, "R4 read data", rdata_o, e_rd);
      chk(drive_o === ed, "R5 R6 R7 drive", {31'd0, drive_o}, {31'd0, ed});
   endtask

   task automatic report;
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #700000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
         report();
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'h5A17;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rdata_o === 32'd0, "R1 rdata reset", rdata_o, 32'd0);
      chk(drive_o === 1'b0, "R1 drive reset", {31'd0, drive_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rdata_o === 32'd0 && drive_o === 1'b0, "R1 after release", rdata_o, 32'd0);

      // prefill every word with a global write
      for (int i = 0; i < NW; i++) begin
         cyc(1'b1, 10'(i), 1'b0, 1'b1, 4'hF, (32'(i) * 32'h9E37_79B9) ^ 32'h0F0F_1234, 1'b0, 1'b0);
      end

      // R2 global write overrides byte controls
      cyc(1'b1, 10'd5, 1'b0, 1'b1, 4'hF, 32'hAABB_CCDD, 1'b0, 1'b0);
      cyc(1'b1, 10'd5, 1'b1, 1'b1, 4'h0, 32'h0, 1'b0, 1'b0);
      chk(rdata_o === 32'hAABB_CCDD, "R2 global write", rdata_o, 32'hAABB_CCDD);
      chk(drive_o === 1'b1, "R5 drive on read", {31'd0, drive_o}, 32'd1);

      // R3 and R8: lanes 0 and 2 written, read back-to-back
      cyc(1'b1, 10'd5, 1'b1, 1'b0, 4'b1010, 32'h1122_3344, 1'b0, 1'b0);
      chk(drive_o === 1'b0, "R5 no drive after write", {31'd0, drive_o}, 32'd0);
      cyc(1'b1, 10'd5, 1'b1, 1'b1, 4'b0000, 32'hFFFF_FFFF, 1'b0, 1'b0);
      chk(rdata_o === 32'hAA22_CC44, "R3 R8 byte write merge", rdata_o, 32'hAA22_CC44);

      // R3: bwe low but no lane selected is a read
      cyc(1'b1, 10'd5, 1'b1, 1'b0, 4'hF, 32'h0, 1'b0, 1'b0);
      chk(rdata_o === 32'hAA22_CC44 && drive_o === 1'b1, "R3 empty byte write reads", rdata_o, 32'hAA22_CC44);

      // R6: first read after deselect is masked
      cyc(1'b0, 10'd5, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0, 1'b0);
      cyc(1'b1, 10'd5, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0, 1'b0);
      chk(drive_o === 1'b0, "R6 first read masked", {31'd0, drive_o}, 32'd0);
      cyc(1'b1, 10'd5, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0);
      chk(drive_o === 1'b0, "R5 oe high no drive", {31'd0, drive_o}, 32'd0);
      oe_n = 1'b0;
      #1;
      chk(drive_o === 1'b1, "R5 async oe", {31'd0, drive_o}, 32'd1);
      oe_n = 1'b1;
      #0.5;
      chk(drive_o === 1'b0, "R5 async oe release", {31'd0, drive_o}, 32'd0);

      // R7: sleep drops a write and holds output
      cyc(1'b1, 10'd5, 1'b0, 1'b0, 4'h0, 32'h0, 1'b0, 1'b1);
      chk(drive_o === 1'b0 && rdata_o === 32'hAA22_CC44, "R7 sleep hold", rdata_o, 32'hAA22_CC44);
      cyc(1'b1, 10'd5, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0, 1'b1);
      chk(drive_o === 1'b0, "R7 sleep no drive", {31'd0, drive_o}, 32'd0);
      cyc(1'b1, 10'd5, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0, 1'b0);
      cyc(1'b1, 10'd5, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0, 1'b0);
      chk(rdata_o === 32'hAA22_CC44, "R7 contents kept", rdata_o, 32'hAA22_CC44);

      // R9: deselected write does nothing
      cyc(1'b0, 10'd5, 1'b0, 1'b0, 4'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
      cyc(1'b1, 10'd5, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0, 1'b0);
      cyc(1'b1, 10'd5, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0, 1'b0);
      chk(rdata_o === 32'hAA22_CC44, "R9 deselect ignored", rdata_o, 32'hAA22_CC44);

      // constrained random mix on a small address window
      for (int n = 0; n < 4000; n++) begin
         logic s, g, b, o, z;
         logic [3:0] bs;
         s  = ($urandom % 100) < 85;
         z  = ($urandom % 100) < 5;
         o  = ($urandom % 100) < 20;
         g  = ($urandom % 100) >= 15;
         b  = ($urandom % 100) >= 40;
         bs = 4'($urandom);
         cyc(s, 10'($urandom % 8), g, b, bs, $urandom, o, z);
      end

      report();
   end

endmodule